// File: doc/BRIEF.md
# Parallel Port Reverse-Direction Negotiator and Receiver

This block sits on the host side of an extended-capability parallel link. It turns the shared 8-bit data path around from host-to-peripheral to peripheral-to-host, collects bytes from the peripheral and then hands the path back to the host. A turnaround starts only when the upper layer asks for the reverse direction and reports that forward traffic has drained or been stopped. The block then lowers its reverse-request line and waits for the peripheral to lower its reverse-acknowledge line. Only after that does it release the host data drivers, so the two sides never drive the bus together.

While the path is reversed, each byte moves by a two-wire handshake. The peripheral lowers its clock line. The host captures the byte, together with a command/data tag taken from the peripheral's tag line, into a receive FIFO and raises its acknowledge. The peripheral raises its clock, and the host lowers its acknowledge. When the FIFO is full, the host keeps its acknowledge low, which stalls the peripheral. To give the path back, the host raises the reverse-request line and waits for the acknowledge line to go high before it re-enables its drivers. The peripheral's "data available" line is synchronised and brought out for the upper layer.

All peripheral-driven control lines pass through a synchroniser. Captured entries are read out of the FIFO head with a pop strobe.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset, hostRevReqN is 1, hostAck is 0, hostDataOe is 1 and rxValid is 0.
- R2: hostRevReqN goes low only when revReq and fwdIdle are both 1. While fwdIdle is 0 it stays high, even if revReq is 1.
- R3: hostDataOe stays 1 while hostRevReqN is low and periphAckRevN is still high. It goes to 0 only after a low on periphAckRevN has been seen.
- R4: A periphClk low level before the reverse acknowledge has no effect: hostAck stays 0 and nothing enters the FIFO.
- R5: In the reverse direction, a periphClk low captures dataIn into the FIFO and raises hostAck. hostAck returns to 0 after periphClk returns high. One byte is captured per low pulse.
- R6: Each entry carries a tag: rxCmd is 1 when periphAck was 0 at capture (command byte) and 0 when periphAck was 1 (data byte).
- R7: With DEPTH entries held, a periphClk low leaves hostAck at 0 and captures nothing. The byte is taken once an entry has been popped.
- R8: Entries leave in arrival order. rxValid is 1 exactly while the FIFO is not empty, and rxData/rxCmd show the oldest entry. rxPop while empty is ignored.
- R9: When revReq drops in the reverse direction with no byte in progress, hostRevReqN returns to 1. hostDataOe is re-enabled only after periphAckRevN is seen high.
- R10: periphHasData is the synchronised inverse of periphReqN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| revReq | input | 1 | Upper layer asks for the reverse direction |
| fwdIdle | input | 1 | Forward traffic drained or stopped |
| hostRevReqN | output | 1 | Reverse-direction request to the peripheral, active low |
| periphAckRevN | input | 1 | Peripheral acknowledge of the reverse request, active low |
| hostDataOe | output | 1 | Enable for the host data drivers |
| periphClk | input | 1 | Peripheral byte strobe, active low |
| periphAck | input | 1 | Peripheral tag line: 0 command, 1 data |
| hostAck | output | 1 | Host byte acknowledge |
| periphReqN | input | 1 | Peripheral reports reverse data available, active low |
| periphHasData | output | 1 | Synchronised data-available indication |
| dataIn | input | DATA_W | Data bus as driven by the peripheral |
| rxPop | input | 1 | Remove the FIFO head entry |
| rxValid | output | 1 | FIFO holds at least one entry |
| rxData | output | DATA_W | Head entry byte |
| rxCmd | output | 1 | Head entry tag, 1 for command |

## Verification
The bench holds back the reverse acknowledge and checks that the drivers stay enabled. A design that released the bus early would show hostDataOe falling while periphAckRevN is still high. It pulses periphClk before the acknowledge, so a design that captured too early would raise hostAck or show rxValid. It fills the FIFO and then offers one more byte. A design that overwrote an entry or let the peripheral run on would raise hostAck or lose the oldest entry. It also checks the return path: enabling the drivers before the peripheral lets go of the bus would show up as hostDataOe rising while periphAckRevN is still low. Random bursts with random tags, and pops on an empty FIFO, cover byte order and the command/data tag.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;
  typedef enum logic [1:0] {
    ST_FWD = 2'd0,
    ST_REQ = 2'd1,
    ST_REV = 2'd2,
    ST_REL = 2'd3
  } dirState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
  } dpStrobe_t;

  // synchronised status from datapath to control
  typedef struct packed {
    logic ackRevLow;
    logic clkLow;
    logic full;
  } dpStatus_t;
endpackage

// File: rtl/ecp_rev_dp.sv
module ecp_rev_dp
  import ecp_rev_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawAckRevN,
  input  logic              rawClk,
  input  logic              rawReqN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              tagIn,
  input  dpStrobe_t         strobe,
  input  logic              popEn,
  output dpStatus_t         status,
  output logic              hasData,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxCmd
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int N_SYNC = 3;
  localparam int ENTRY_W = DATA_W + 1;

  logic [N_SYNC-1:0] rawVec;
  logic [N_SYNC-1:0] syncOut;
  assign rawVec = {rawReqN, rawClk, rawAckRevN};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawVec[g]};
    end
    assign syncOut[g] = chain[SYNC_STAGES-1];
  end

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic full, empty, doPop;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign doPop = popEn && !empty;

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= {~tagIn, dataIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push)
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)
        rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign status.ackRevLow = ~syncOut[0];
  assign status.clkLow    = ~syncOut[1];
  assign status.full      = full;
  assign hasData          = ~syncOut[2];
  assign rxValid          = !empty;
  assign rxData           = mem[rdPtr][DATA_W-1:0];
  assign rxCmd            = mem[rdPtr][DATA_W];

  // R7: control never pushes into a full FIFO
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !full);
  // R8: a pop on an empty FIFO leaves it empty
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && empty && !strobe.push) |=> !rxValid);
endmodule

// File: rtl/ecp_rev_ctrl.sv
module ecp_rev_ctrl
  import ecp_rev_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      revReq,
  input  logic      fwdIdle,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      revReqN,
  output logic      dataOe,
  output logic      hostAck
);
  dirState_t state, stateNext;
  logic revReqNNext, dataOeNext, hostAckNext;

  always_comb begin
    stateNext   = state;
    revReqNNext = revReqN;
    dataOeNext  = dataOe;
    hostAckNext = hostAck;
    strobe      = '0;
    case (state)
      ST_FWD: begin
        if (revReq && fwdIdle) begin
          stateNext   = ST_REQ;
          revReqNNext = 1'b0;
        end
      end
      ST_REQ: begin
        if (!revReq) begin
          stateNext   = ST_REL;
          revReqNNext = 1'b1;
        end else if (status.ackRevLow) begin
          stateNext  = ST_REV;
          dataOeNext = 1'b0;
        end
      end
      ST_REV: begin
        if (hostAck) begin
          if (!status.clkLow) hostAckNext = 1'b0;
        end else if (status.clkLow) begin
          if (!status.full) begin
            strobe.push = 1'b1;
            hostAckNext = 1'b1;
          end
        end else if (!revReq) begin
          stateNext   = ST_REL;
          revReqNNext = 1'b1;
        end
      end
      ST_REL: begin
        if (!status.ackRevLow) begin
          stateNext  = ST_FWD;
          dataOeNext = 1'b1;
        end
      end
      default: stateNext = ST_FWD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_FWD;
      revReqN <= 1'b1;
      dataOe  <= 1'b1;
      hostAck <= 1'b0;
    end else begin
      state   <= stateNext;
      revReqN <= revReqNNext;
      dataOe  <= dataOeNext;
      hostAck <= hostAckNext;
    end
  end

  // R2: request only after forward traffic is idle
  p_req_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(revReqN) |-> $past(revReq && fwdIdle));
  // R3: drivers released only after the acknowledge is seen
  p_oe_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataOe) |-> $past(status.ackRevLow) && !revReqN);
  // R4: no byte acknowledge while the host still drives the bus
  p_ack_reverse_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> !dataOe);
  // R5: acknowledge rises only on a strobe with room in the FIFO
  p_ack_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostAck) |-> $past(status.clkLow && !status.full));
  // R9: drivers come back only after the peripheral let go
  p_oe_return_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> $past(!status.ackRevLow) && revReqN);
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
  import ecp_rev_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              revReq,
  input  logic              fwdIdle,
  output logic              hostRevReqN,
  input  logic              periphAckRevN,
  output logic              hostDataOe,
  input  logic              periphClk,
  input  logic              periphAck,
  output logic              hostAck,
  input  logic              periphReqN,
  output logic              periphHasData,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rxPop,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxCmd
);
  dpStrobe_t strobe;
  dpStatus_t status;

  ecp_rev_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .revReq  (revReq),
    .fwdIdle (fwdIdle),
    .status  (status),
    .strobe  (strobe),
    .revReqN (hostRevReqN),
    .dataOe  (hostDataOe),
    .hostAck (hostAck)
  );

  ecp_rev_dp #(
    .DATA_W      (DATA_W),
    .DEPTH       (DEPTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rawAckRevN (periphAckRevN),
    .rawClk     (periphClk),
    .rawReqN    (periphReqN),
    .dataIn     (dataIn),
    .tagIn      (periphAck),
    .strobe     (strobe),
    .popEn      (rxPop),
    .status     (status),
    .hasData    (periphHasData),
    .rxValid    (rxValid),
    .rxData     (rxData),
    .rxCmd      (rxCmd)
  );
endmodule

// File: tb/test_ecp_rev_rx.sv
module test_ecp_rev_rx;
  localparam int DATA_W = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic revReq = 1'b0, fwdIdle = 1'b0;
  logic periphAckRevN = 1'b1, periphClk = 1'b1, periphAck = 1'b1, periphReqN = 1'b1;
  logic [DATA_W-1:0] dataIn = '0;
  logic rxPop = 1'b0;
  logic hostRevReqN, hostDataOe, hostAck, periphHasData, rxValid, rxCmd;
  logic [DATA_W-1:0] rxData;

  int vectors = 0;
  int miscompares = 0;
  logic [DATA_W-1:0] expData [256];
  logic expCmd [256];
  int wrIdx = 0, rdIdx = 0;

  always #2 clk = ~clk;

  ecp_rev_rx #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_ecp_rev_rx (
    .clk(clk), .rstN(rstN), .revReq(revReq), .fwdIdle(fwdIdle),
    .hostRevReqN(hostRevReqN), .periphAckRevN(periphAckRevN),
    .hostDataOe(hostDataOe), .periphClk(periphClk), .periphAck(periphAck),
    .hostAck(hostAck), .periphReqN(periphReqN), .periphHasData(periphHasData),
    .dataIn(dataIn), .rxPop(rxPop), .rxValid(rxValid), .rxData(rxData),
    .rxCmd(rxCmd)
  );

  function automatic logic tagOf(input logic ackLine);
    return !ackLine; // command when the tag line is low
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitAck(input logic val, input string req);
    int t = 0;
    while (hostAck !== val && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(req, hostAck, val);
  endtask

  task automatic sendByte(input logic [DATA_W-1:0] d, input logic isCmd);
    @(negedge clk);
    dataIn = d;
    periphAck = !isCmd;
    periphClk = 1'b0;
    expData[wrIdx] = d;
    expCmd[wrIdx] = tagOf(!isCmd);
    wrIdx++;
    waitAck(1'b1, "R5 ack rise");
    periphClk = 1'b1;
    waitAck(1'b0, "R5 ack fall");
    dataIn = $urandom;
    periphAck = $urandom;
  endtask

  task automatic popOne();
    @(negedge clk);
    check("R8 valid", rxValid, 1'b1);
    check("R8 order data", rxData, expData[rdIdx]);
    check("R6 tag", rxCmd, expCmd[rdIdx]);
    rxPop = 1'b1;
    rdIdx++;
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  initial begin
    cycles(150000);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1284));
    cycles(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reqN", hostRevReqN, 1'b1);
    check("R1 hostAck", hostAck, 1'b0);
    check("R1 oe", hostDataOe, 1'b1);
    check("R1 rxValid", rxValid, 1'b0);

    // R10 data-available line
    periphReqN = 1'b0;
    cycles(4);
    check("R10 has data", periphHasData, 1'b1);
    periphReqN = 1'b1;
    cycles(4);
    check("R10 no data", periphHasData, 1'b0);

    // R2 no request while forward busy
    revReq = 1'b1;
    cycles(10);
    check("R2 held while busy", hostRevReqN, 1'b1);
    // R4 strobe before acknowledge is ignored
    periphClk = 1'b0;
    fwdIdle = 1'b1;
    cycles(4);
    check("R2 request", hostRevReqN, 1'b0);
    cycles(10);
    check("R3 oe held", hostDataOe, 1'b1);
    check("R4 no ack", hostAck, 1'b0);
    check("R4 no capture", rxValid, 1'b0);
    periphClk = 1'b1;
    cycles(4);
    periphAckRevN = 1'b0;
    cycles(5);
    check("R3 oe released", hostDataOe, 1'b0);
    check("R4 still empty", rxValid, 1'b0);

    // R8 pop on empty ignored
    @(negedge clk); rxPop = 1'b1;
    @(negedge clk); rxPop = 1'b0;
    check("R8 empty pop", rxValid, 1'b0);

    // random bursts
    for (int b = 0; b < 12; b++) begin
      int n = 1 + ($urandom % DEPTH);
      for (int k = 0; k < n; k++) sendByte($urandom, $urandom % 2);
      while (rdIdx < wrIdx) popOne();
      @(negedge clk);
      check("R8 drained", rxValid, 1'b0);
    end

    // R7 full stall
    for (int k = 0; k < DEPTH; k++) sendByte($urandom, k[0]);
    @(negedge clk);
    dataIn = 8'hA5;
    periphAck = 1'b0;
    periphClk = 1'b0;
    expData[wrIdx] = 8'hA5;
    expCmd[wrIdx] = 1'b1;
    wrIdx++;
    cycles(20);
    check("R7 stall ack", hostAck, 1'b0);
    popOne();
    waitAck(1'b1, "R7 resumes");
    periphClk = 1'b1;
    waitAck(1'b0, "R5 ack fall");
    while (rdIdx < wrIdx) popOne();

    // R9 return to forward
    revReq = 1'b0;
    cycles(4);
    check("R9 reqN high", hostRevReqN, 1'b1);
    cycles(10);
    check("R9 oe held", hostDataOe, 1'b0);
    periphAckRevN = 1'b1;
    cycles(5);
    check("R9 oe back", hostDataOe, 1'b1);
    check("R9 ack idle", hostAck, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule